// File: doc/BRIEF.md
# Indirect-Window Interrupt Redirection Controller

This block routes a set of external interrupt pins to interrupt messages. Every pin owns one redirection entry that gives the vector to deliver, the destination to steer it to, a trigger mode (edge or level) and a mask. When a pin fires, the block offers a message of vector and destination on a valid/ready output. The message stays on the output until the consumer accepts it.

Software never sees the redirection table directly. Two 32-bit registers sit in a small window at a base address: an index register and a data register. A write to the index register picks an internal register. Later reads and writes of the data register reach the register that the index currently names. The base address is the parameter `BASE_ADDR` (default 0xFEC00000), so the window can be placed anywhere at integration.

Level-triggered pins need an end-of-interrupt before they can deliver again. Once a level message has been accepted, the entry's remote-acknowledge flag is set. It is cleared only by an end-of-interrupt pulse that carries the same vector. Dispatch runs as a two-state machine. In IDLE, any request moves it to SEND, and the lowest-numbered requesting pin is captured on that move. In SEND it waits while ready is low and goes back to IDLE when the message is accepted.

Top module: `ioirq_router`

## Requirements
- R1: A full access at BASE_ADDR+0x00 writes or reads the index register, which reads back in bits 7:0. A full access at BASE_ADDR+0x10 writes or reads the internal register named by the current index.
- R2: An access counts as full only if all four byte enables are set and the address is one of the two window offsets. Any other access changes nothing and reads as zero. An index that names no register also reads as zero.
- R3: After reset, every entry's low word reads 0x00010000 (masked, edge, vector 0), every high word reads 0, and no message is valid.
- R4: Index 0x01 is read-only and reads {8'h00, NUM_PINS-1, 8'h00, 8'h20}.
- R5: Pin n has its low word at index 0x10+2n and its high word at index 0x11+2n. Low word: bits 7:0 vector, bit 14 remote-acknowledge (read-only), bit 15 trigger (1 = level), bit 16 mask. High word: bits 31:24 destination. All other bits read zero.
- R6: On an unmasked edge-mode pin, a rising edge sets a pending flag, which produces exactly one message carrying the entry's vector and destination. Accepting that message clears the flag. Holding the pin high afterwards produces no further message.
- R7: A rising edge on a masked edge-mode pin is dropped. Clearing the mask later does not produce a message for it.
- R8: An asserted, unmasked level-mode pin produces a message, and accepting that message sets remote-acknowledge. While remote-acknowledge is set, no further message comes from that pin. An end-of-interrupt pulse whose vector matches the entry's vector clears it, and delivery then resumes if the pin is still asserted.
- R9: An end-of-interrupt pulse whose vector differs from the entry's vector leaves remote-acknowledge set.
- R10: When several pins request at once, the lowest-numbered pin's message is sent first. The others follow in ascending order.
- R11: While a message is valid and ready is low, valid, vector and destination all hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during a read strobe |
| irq_pins | input | NUM_PINS | Interrupt input pins |
| eoi_valid | input | 1 | End-of-interrupt pulse |
| eoi_vector | input | 8 | Vector being acknowledged |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_vector | output | 8 | Message vector |
| msg_dest | output | 8 | Message destination |

## Verification
Several stimulus patterns are used, and each one isolates a different failure.
- **Single pins in each mode.** A single edge pulse and a single level assertion show the two trigger modes behave differently. A pin held high after acceptance is the case that separates edge detection from level sensing.
- **Simultaneous requests.** Raising two pins together, with ready held low, checks lowest-first ordering and the holding of the message.
- **End-of-interrupt vectors.** Sending a wrong vector and then the right one shows that the remote-acknowledge flag reacts only to a matching vector.
- **Bad accesses.** Partial and misaligned accesses check that nothing outside the two full-word offsets reaches the window.
- **Random traffic.** A seeded random series of pins, vectors, destinations and ready delays checks that the table contents are carried into the message for every entry.

// File: rtl/ioirq_pkg.sv
package ioirq_pkg;
    localparam logic [7:0] IDX_VERSION = 8'h01;
    localparam logic [7:0] IDX_TABLE   = 8'h10;
    localparam logic [7:0] VERSION_ID  = 8'h20;

    typedef struct packed {
        logic [7:0] dest;
        logic       mask;
        logic       lvl;
        logic [7:0] vec;
    } rte_t;

    typedef enum logic {
        ST_IDLE,
        ST_SEND
    } disp_state_t;
endpackage

// File: rtl/ioirq_regs.sv
module ioirq_regs
    import ioirq_pkg::*;
#(
    parameter int          NUM_PINS  = 8,
    parameter logic [31:0] BASE_ADDR = 32'hFEC0_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [31:0]         bus_addr,
    input  logic [3:0]          bus_be,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] rirr,
    output logic [7:0]          vec_o [NUM_PINS],
    output logic [7:0]          dest_o [NUM_PINS],
    output logic [NUM_PINS-1:0] lvl_o,
    output logic [NUM_PINS-1:0] mask_o
);
    localparam logic [31:0] DATA_ADDR = BASE_ADDR + 32'h10;

    logic       full;
    logic       hit_idx;
    logic       hit_dat;
    logic [7:0] index;
    logic [31:0] data_word;
    rte_t       tbl [NUM_PINS];
    logic       unused_bits;

    assign full    = bus_valid && (bus_be == 4'hF) && (bus_addr[1:0] == 2'b00);
    assign hit_idx = full && (bus_addr == BASE_ADDR);
    assign hit_dat = full && (bus_addr == DATA_ADDR);
    assign unused_bits = ^{bus_wdata[23:17], bus_wdata[14:8]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index <= '0;
        end else if (hit_idx && bus_write) begin
            index <= bus_wdata[7:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < NUM_PINS; n++) begin
                tbl[n] <= '{dest: 8'h00, mask: 1'b1, lvl: 1'b0, vec: 8'h00};
            end
        end else if (hit_dat && bus_write) begin
            for (int n = 0; n < NUM_PINS; n++) begin
                if (index == 8'(IDX_TABLE + 2*n)) begin
                    tbl[n].vec  <= bus_wdata[7:0];
                    tbl[n].lvl  <= bus_wdata[15];
                    tbl[n].mask <= bus_wdata[16];
                end
                if (index == 8'(IDX_TABLE + 2*n + 1)) begin
                    tbl[n].dest <= bus_wdata[31:24];
                end
            end
        end
    end

    always_comb begin
        data_word = '0;
        if (index == IDX_VERSION) begin
            data_word = {8'h00, 8'(NUM_PINS-1), 8'h00, VERSION_ID};
        end
        for (int n = 0; n < NUM_PINS; n++) begin
            if (index == 8'(IDX_TABLE + 2*n)) begin
                data_word = {15'b0, tbl[n].mask, tbl[n].lvl, rirr[n], 6'b0, tbl[n].vec};
            end
            if (index == 8'(IDX_TABLE + 2*n + 1)) begin
                data_word = {tbl[n].dest, 24'b0};
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (!bus_write && hit_idx) begin
            bus_rdata = {24'b0, index};
        end else if (!bus_write && hit_dat) begin
            bus_rdata = data_word;
        end
    end

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_out
        assign vec_o[n]  = tbl[n].vec;
        assign dest_o[n] = tbl[n].dest;
        assign lvl_o[n]  = tbl[n].lvl;
        assign mask_o[n] = tbl[n].mask;
    end

    // R2: a partial or misaligned write never moves the index
    p_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && !full) |=> $stable(index));
endmodule

// File: rtl/ioirq_pin.sv
module ioirq_pin (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic       lvl,
    input  logic       mask,
    input  logic [7:0] vec,
    input  logic       eoi_valid,
    input  logic [7:0] eoi_vector,
    input  logic       accept,
    output logic       req,
    output logic       rirr
);
    logic prev;
    logic pend;
    logic eoi_hit;

    assign eoi_hit = eoi_valid && (eoi_vector == vec);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= 1'b0;
            pend <= 1'b0;
            rirr <= 1'b0;
        end else begin
            prev <= pin;
            if (lvl) begin
                pend <= 1'b0;
            end else begin
                if (accept) pend <= 1'b0;
                if (pin && !prev && !mask) pend <= 1'b1;
            end
            if (lvl && accept) begin
                rirr <= 1'b1;
            end else if (!lvl || eoi_hit) begin
                rirr <= 1'b0;
            end
        end
    end

    assign req = lvl ? (pin && !mask && !rirr) : (pend && !mask);

    // R7: pending only ever rises from an unmasked rising input
    p_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(!mask && pin));
    // R6: pending only drops on acceptance or a mode change
    p_pend_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend) |-> $past(accept || lvl));
    // R8: remote acknowledge is set only by an accepted message
    p_rirr_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rirr) |-> $past(accept));
    // R9: without a matching end-of-interrupt the flag stays set
    p_eoi_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rirr && lvl && !eoi_hit) |=> rirr);
endmodule

// File: rtl/ioirq_dispatch.sv
module ioirq_dispatch
    import ioirq_pkg::*;
#(
    parameter int NUM_PINS = 8,
    localparam int SEL_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] req,
    input  logic [7:0]          vec_i [NUM_PINS],
    input  logic [7:0]          dest_i [NUM_PINS],
    input  logic                out_ready,
    output logic                out_valid,
    output logic [7:0]          out_vector,
    output logic [7:0]          out_dest,
    output logic [NUM_PINS-1:0] accept_vec
);
    disp_state_t state, nxt;
    logic [SEL_W-1:0] sel, pick;
    logic             found;
    logic [7:0]       vec_q, dest_q;

    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = NUM_PINS-1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                pick  = SEL_W'(i);
            end
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (found) nxt = ST_SEND;
            ST_SEND: if (out_ready) nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            sel    <= '0;
            vec_q  <= '0;
            dest_q <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && found) begin
                sel    <= pick;
                vec_q  <= vec_i[pick];
                dest_q <= dest_i[pick];
            end
        end
    end

    always_comb begin
        out_valid  = (state == ST_SEND);
        out_vector = vec_q;
        out_dest   = dest_q;
        accept_vec = '0;
        if (state == ST_SEND && out_ready) accept_vec[sel] = 1'b1;
    end

    // R11: an unaccepted message holds steady
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_vector) && $stable(out_dest)));
    // R10: at most one pin is acknowledged per accept
    p_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(accept_vec));
endmodule

// File: rtl/ioirq_router.sv
module ioirq_router
    import ioirq_pkg::*;
#(
    parameter int          NUM_PINS  = 8,
    parameter logic [31:0] BASE_ADDR = 32'hFEC0_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [31:0]         bus_addr,
    input  logic [3:0]          bus_be,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] irq_pins,
    input  logic                eoi_valid,
    input  logic [7:0]          eoi_vector,
    output logic                msg_valid,
    input  logic                msg_ready,
    output logic [7:0]          msg_vector,
    output logic [7:0]          msg_dest
);
    logic [7:0]          vec [NUM_PINS];
    logic [7:0]          dest [NUM_PINS];
    logic [NUM_PINS-1:0] lvl, mask, rirr, req, accept_vec;

    ioirq_regs #(.NUM_PINS(NUM_PINS), .BASE_ADDR(BASE_ADDR)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rirr(rirr), .vec_o(vec), .dest_o(dest), .lvl_o(lvl), .mask_o(mask)
    );

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        ioirq_pin u_pin (
            .clk(clk), .rst_n(rst_n), .pin(irq_pins[n]),
            .lvl(lvl[n]), .mask(mask[n]), .vec(vec[n]),
            .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
            .accept(accept_vec[n]), .req(req[n]), .rirr(rirr[n])
        );
    end

    ioirq_dispatch #(.NUM_PINS(NUM_PINS)) u_disp (
        .clk(clk), .rst_n(rst_n), .req(req),
        .vec_i(vec), .dest_i(dest), .out_ready(msg_ready),
        .out_valid(msg_valid), .out_vector(msg_vector), .out_dest(msg_dest),
        .accept_vec(accept_vec)
    );
endmodule

// File: tb/ioirq_router_bench.sv
module ioirq_router_bench;
    localparam int          NP   = 8;
    localparam logic [31:0] BASE = 32'hFEC0_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
    logic [3:0]  bus_be = 4'hF;
    logic [NP-1:0] irq_pins = '0;
    logic        eoi_valid = 1'b0;
    logic [7:0]  eoi_vector = '0;
    logic        msg_valid, msg_ready = 1'b0;
    logic [7:0]  msg_vector, msg_dest;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;

    ioirq_router #(.NUM_PINS(NP), .BASE_ADDR(BASE)) u_ioirq_router (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_pins(irq_pins), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector), .msg_dest(msg_dest)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    function automatic logic [31:0] lo_word(logic [7:0] v, logic lv, logic m, logic ra);
        return {15'b0, m, lv, ra, 6'b0, v};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(logic [31:0] a, logic [31:0] d, logic [3:0] be = 4'hF);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_valid = 0; bus_write = 0; bus_be = 4'hF;
    endtask

    task automatic bus_rd(logic [31:0] a, output logic [31:0] d, input logic [3:0] be = 4'hF);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = a; bus_be = be;
        #1 d = bus_rdata;
        bus_valid = 0; bus_be = 4'hF;
    endtask

    task automatic reg_wr(logic [7:0] idx, logic [31:0] d);
        bus_wr(BASE, {24'b0, idx});
        bus_wr(BASE + 32'h10, d);
    endtask

    task automatic reg_rd(logic [7:0] idx, output logic [31:0] d);
        bus_wr(BASE, {24'b0, idx});
        bus_rd(BASE + 32'h10, d);
    endtask

    task automatic wait_msg(output bit got);
        got = 0;
        for (int k = 0; k < 30 && !got; k++) begin
            @(negedge clk);
            if (msg_valid) got = 1;
        end
    endtask

    task automatic take();
        msg_ready = 1;
        @(negedge clk);
        msg_ready = 0;
    endtask

    task automatic quiet(int n, output bit clean);
        clean = 1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (msg_valid) clean = 0;
        end
    endtask

    task automatic eoi(logic [7:0] v);
        @(negedge clk);
        eoi_valid = 1; eoi_vector = v;
        @(negedge clk);
        eoi_valid = 0;
    endtask

    initial begin
        logic [31:0] rd;
        bit got, clean;
        logic [7:0] v, d;
        int p;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst_n = 1;

        // R3 reset state
        check("R3 valid", {31'b0, msg_valid}, 0);
        reg_rd(8'h10, rd); check("R3 entry0 lo", rd, 32'h0001_0000);
        reg_rd(8'h10 + 2*(NP-1) + 1, rd); check("R3 last hi", rd, 0);

        // R4 version
        reg_rd(8'h01, rd); check("R4 version", rd, {8'h00, 8'(NP-1), 8'h00, 8'h20});

        // R1 index readback, R5 layout
        bus_wr(BASE, 32'h0000_0015);
        bus_rd(BASE, rd); check("R1 index readback", rd, 32'h15);
        reg_wr(8'h18, 32'hFFFF_FF44);
        reg_rd(8'h18, rd); check("R5 lo field mask", rd, lo_word(8'h44, 1, 1, 0));
        reg_wr(8'h19, 32'hABFF_FFFF);
        reg_rd(8'h19, rd); check("R5 hi field mask", rd, 32'hAB00_0000);

        // R2 ignored accesses
        reg_wr(8'h18, lo_word(8'h44, 0, 1, 0));
        bus_wr(BASE + 32'h10, 32'h99, 4'h1);
        bus_wr(BASE + 32'h12, 32'h77);
        bus_rd(BASE + 32'h10, rd); check("R2 partial write dropped", rd, lo_word(8'h44, 0, 1, 0));
        bus_rd(BASE + 32'h10, rd, 4'h3); check("R2 partial read zero", rd, 0);
        bus_rd(BASE + 32'h04, rd); check("R2 other offset zero", rd, 0);
        bus_rd(BASE + 32'h12, rd); check("R2 misaligned zero", rd, 0);
        bus_wr(BASE, 32'h01, 4'h1);
        bus_rd(BASE, rd); check("R2 index kept", rd, 32'h18);
        reg_rd(8'h10 + 2*NP, rd); check("R2 unused index zero", rd, 0);

        // R6 edge, pin held high
        reg_wr(8'h11, 32'h3C00_0000);
        reg_wr(8'h10, lo_word(8'h30, 0, 0, 0));
        @(negedge clk); irq_pins[0] = 1;
        wait_msg(got); check("R6 edge delivered", {31'b0, got}, 1);
        check("R6 vector", {24'b0, msg_vector}, 32'h30);
        check("R6 dest", {24'b0, msg_dest}, 32'h3C);
        take();
        quiet(10, clean); check("R6 no repeat while held", {31'b0, clean}, 1);
        irq_pins[0] = 0;

        // R10 priority and R11 hold
        reg_wr(8'h14, lo_word(8'h52, 0, 0, 0)); reg_wr(8'h15, 32'h0200_0000);
        reg_wr(8'h1A, lo_word(8'h55, 0, 0, 0)); reg_wr(8'h1B, 32'h0500_0000);
        @(negedge clk); irq_pins[2] = 1; irq_pins[5] = 1;
        wait_msg(got); check("R10 first vector", {24'b0, msg_vector}, 32'h52);
        repeat (3) @(negedge clk);
        check("R11 valid held", {31'b0, msg_valid}, 1);
        check("R11 vector held", {24'b0, msg_vector}, 32'h52);
        check("R11 dest held", {24'b0, msg_dest}, 32'h02);
        take();
        wait_msg(got); check("R10 second vector", {24'b0, msg_vector}, 32'h55);
        take();
        irq_pins[2] = 0; irq_pins[5] = 0;

        // R7 masked edge dropped
        reg_wr(8'h1C, lo_word(8'h66, 0, 1, 0));
        @(negedge clk); irq_pins[6] = 1;
        @(negedge clk); irq_pins[6] = 0;
        quiet(8, clean); check("R7 masked silent", {31'b0, clean}, 1);
        reg_wr(8'h1C, lo_word(8'h66, 0, 0, 0));
        quiet(8, clean); check("R7 unmask no late msg", {31'b0, clean}, 1);

        // R8/R9 level with remote acknowledge
        reg_wr(8'h17, 32'h0300_0000);
        reg_wr(8'h16, lo_word(8'h43, 1, 0, 0));
        @(negedge clk); irq_pins[3] = 1;
        wait_msg(got); check("R8 level delivered", {31'b0, got}, 1);
        check("R8 level vector", {24'b0, msg_vector}, 32'h43);
        take();
        quiet(8, clean); check("R8 blocked by ack flag", {31'b0, clean}, 1);
        reg_rd(8'h16, rd); check("R8 flag readback", rd, lo_word(8'h43, 1, 0, 1));
        eoi(8'h44);
        quiet(8, clean); check("R9 wrong eoi ignored", {31'b0, clean}, 1);
        reg_rd(8'h16, rd); check("R9 flag still set", rd, lo_word(8'h43, 1, 0, 1));
        eoi(8'h43);
        wait_msg(got); check("R8 redelivered after eoi", {31'b0, got}, 1);
        take();
        irq_pins[3] = 0;
        eoi(8'h43);
        quiet(8, clean); check("R8 idle when pin low", {31'b0, clean}, 1);
        reg_rd(8'h16, rd); check("R8 flag cleared", rd, lo_word(8'h43, 1, 0, 0));

        // R6 random edge traffic
        for (int it = 0; it < 40; it++) begin
            p = $urandom % NP;
            v = 8'($urandom); d = 8'($urandom);
            reg_wr(8'(16 + 2*p + 1), {d, 24'b0});
            reg_wr(8'(16 + 2*p), lo_word(v, 0, 0, 0));
            @(negedge clk); irq_pins[p] = 1;
            @(negedge clk); irq_pins[p] = 0;
            wait_msg(got);
            repeat ($urandom % 3) @(negedge clk);
            check("R6 random vector", {23'b0, got, msg_vector}, {23'b0, 1'b1, v});
            check("R6 random dest", {24'b0, msg_dest}, {24'b0, d});
            take();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule